// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Pulse Generator

This block drives two pulse lines from one free-running up-counter. The counter runs through six time units per period, and one unit is a fixed number of clock cycles set by a parameter. Line A is high for the first two units of each period. Line B is high for units three and four, counted from zero. Each line is therefore high for two units and low for four. A dead unit separates the end of either line's pulse from the start of the other's, on both sides.

With the default of 140 cycles per unit and a 168 MHz clock, the period is 840 cycles, which is 5 µs. All three outputs come straight from flip-flops, so each edge falls on a known count and carries no glitch. When the enable input goes low, the counter returns to zero and all outputs go low. When enable goes high again, a new period starts with line A's pulse. A one-cycle strobe marks each wrap of the counter from its last count back to zero.

Top module: `dual_phase_pulse`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are 0 after that edge, and the next run starts at count 0.
- R2: Within each period (count 0 .. 6*UNIT-1), `pulse_a` is 1 exactly for counts 0 .. 2*UNIT-1.
- R3: `pulse_b` is 1 exactly for counts 3*UNIT .. 5*UNIT-1 of each period.
- R4: `pulse_a` and `pulse_b` are never 1 in the same cycle.
- R5: `pulse_b` rises exactly UNIT cycles after `pulse_a` falls.
- R6: `pulse_a` rises exactly UNIT cycles after `pulse_b` falls, when the counter wraps inside a run.
- R7: The period is 6*UNIT cycles. `wrap` is 1 for exactly one cycle each time the count goes from 6*UNIT-1 back to 0, and in that cycle `pulse_a` is 1.
- R8: While `en` is 0, all outputs stay 0. On the first edge with `en` at 1 after it was 0, the count is 0 and `pulse_a` is 1, but `wrap` stays 0.
- R9: If `en` drops in the cycle where the count is 6*UNIT-1, the following cycle shows no `wrap` and no `pulse_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the counter at 0 and the outputs low |
| pulse_a | output | 1 | Phase A pulse, high for units 0 and 1 |
| pulse_b | output | 1 | Phase B pulse, high for units 3 and 4 |
| wrap | output | 1 | One-cycle strobe when the counter returns to 0 |

## Verification
Two things happen in the same cycle at every wrap: the wrap strobe fires and line A rises. The bench checks both on each period boundary. It also checks that the strobe is never seen without line A. The second collision is a disable that arrives exactly on the last count. The bench drops `en` in that cycle and expects the next cycle to show neither the strobe nor the start of a new A pulse. It also confirms that A's next pulse starts only once the block is enabled again.

// File: rtl/dual_phase_pulse.sv
module dual_phase_pulse #(
  parameter int UNIT = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse_a,
  output logic pulse_b,
  output logic wrap
);
  localparam int PERIOD = 6 * UNIT;
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] A_END   = CW'(2 * UNIT);
  localparam logic [CW-1:0] B_START = CW'(3 * UNIT);
  localparam logic [CW-1:0] B_END   = CW'(5 * UNIT);
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          run;
  logic          at_last;

  assign at_last = run && (cnt == LAST);
  assign cnt_n   = (!en || !run || at_last) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      pulse_a <= 1'b0;
      pulse_b <= 1'b0;
      wrap    <= 1'b0;
    end else begin
      run     <= en;
      cnt     <= cnt_n;
      pulse_a <= en && (cnt_n < A_END);
      pulse_b <= en && (cnt_n >= B_START) && (cnt_n < B_END);
      wrap    <= en && at_last;
    end
  end

  // Checks: dead-gap counter tracks cycles since either line fell
  logic          a_d, b_d;
  logic [CW-1:0] gap;
  logic          fell_any;
  assign fell_any = (a_d && !pulse_a) || (b_d && !pulse_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d <= 1'b0;
      b_d <= 1'b0;
      gap <= '0;
    end else begin
      a_d <= pulse_a;
      b_d <= pulse_b;
      if (fell_any)      gap <= CW'(1);
      else if (&gap == 1'b0) gap <= gap + 1'b1;
    end
  end

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(pulse_a && pulse_b));
  p_gap_b_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_b && !b_d) |-> (gap == CW'(UNIT)));
  p_gap_a_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (gap == CW'(UNIT)));
  p_wrap_with_a_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |-> pulse_a);
  p_wrap_single_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pulse_a && !pulse_b && !wrap));
endmodule

// File: tb/test_dual_phase_pulse.sv
module test_dual_phase_pulse;
  localparam int U = 5;
  localparam int P = 6 * U;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pa, pb, w;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_phase_pulse #(.UNIT(U)) i_dual_phase_pulse (
    .clk(clk), .rst(rst), .en(en), .pulse_a(pa), .pulse_b(pb), .wrap(w)
  );

  // cycle offset after start, expected a, b, wrap
  typedef struct packed { logic [7:0] k; logic a; logic b; logic w; } vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'd0,  1'b1, 1'b0, 1'b0},  // R2 start
    '{8'd9,  1'b1, 1'b0, 1'b0},  // R2 last A count
    '{8'd10, 1'b0, 1'b0, 1'b0},  // R2 A falls
    '{8'd14, 1'b0, 1'b0, 1'b0},  // R5 dead unit
    '{8'd15, 1'b0, 1'b1, 1'b0},  // R3 R5 B rises
    '{8'd24, 1'b0, 1'b1, 1'b0},  // R3
    '{8'd25, 1'b0, 1'b0, 1'b0},  // R3 B falls
    '{8'd29, 1'b0, 1'b0, 1'b0},  // R6 dead unit
    '{8'd30, 1'b1, 1'b0, 1'b1},  // R6 R7 wrap with A
    '{8'd31, 1'b1, 1'b0, 1'b0},  // R7 single cycle
    '{8'd40, 1'b0, 1'b0, 1'b0},  // R2
    '{8'd45, 1'b0, 1'b1, 1'b0},  // R3
    '{8'd59, 1'b0, 1'b0, 1'b0},  // R6
    '{8'd60, 1'b1, 1'b0, 1'b1}   // R7
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pulse_a", pa, 1'b0);
    chk("R1", "pulse_b", pb, 1'b0);
    chk("R1", "wrap", w, 1'b0);
    rst = 1'b0;
    // R8 idle while disabled
    repeat (4) @(negedge clk);
    chk("R8", "idle a", pa, 1'b0);
    chk("R8", "idle b", pb, 1'b0);
    en = 1'b1;

    // table walk plus per-cycle model
    for (int k = 0; k <= 65; k++) begin
      @(negedge clk);
      begin
        int m;
        m = k % P;
        chk("R2", "model a", pa, logic'(m < 2 * U));
        chk("R3", "model b", pb, logic'(m >= 3 * U && m < 5 * U));
        chk("R7", "model wrap", w, logic'(k > 0 && m == 0));
        chk("R4", "exclusive", logic'(pa && pb), 1'b0);
      end
      for (int v = 0; v < NV; v++) begin
        if (int'(VEC[v].k) == k) begin
          chk("R7", "table a", pa, VEC[v].a);
          chk("R7", "table b", pb, VEC[v].b);
          chk("R7", "table wrap", w, VEC[v].w);
        end
      end
    end

    // R8 disable mid-run, hold, restart from count 0
    en = 1'b0;
    @(negedge clk);
    chk("R8", "disabled a", pa, 1'b0);
    chk("R8", "disabled b", pb, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8", "held a", pa, 1'b0);
    en = 1'b1;
    @(negedge clk);
    chk("R8", "restart a", pa, 1'b1);
    chk("R8", "restart no wrap", w, 1'b0);
    repeat (10) @(negedge clk);
    chk("R8", "restart A ends at 2U", pa, 1'b0);

    // R9 disable exactly on the last count
    repeat (P - 11) @(negedge clk);   // now at count P-1
    chk("R9", "pre a", pa, 1'b0);
    en = 1'b0;
    @(negedge clk);
    chk("R9", "no wrap", w, 1'b0);
    chk("R9", "no A", pa, 1'b0);
    @(negedge clk);
    chk("R9", "still no A", pa, 1'b0);

    // R1 reset mid-run
    en = 1'b1;
    repeat (17) @(negedge clk);
    chk("R1", "b before reset", pb, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset b", pb, 1'b0);
    chk("R1", "reset a", pa, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post reset start a", pa, 1'b1);
    chk("R1", "post reset no wrap", w, 1'b0);

    finish_run();
  end
endmodule